// File: doc/BRIEF.md
# Timed Command Interpreter

This block takes 32-bit control words from a link and decodes them. The upper half of each word is a header and the lower half is a data field. Commands fall into three classes. An immediate command acts in the cycle it arrives. Interface commands and chip commands wait in a first-in first-out queue and leave it strictly in arrival order. A 15-bit timer runs freely from reset, and every executed command takes its value as its timestamp.

One immediate command arms a hold. While the hold is armed, the next queued command does not run until the timer reaches a programmed value. Every accepted command is echoed on a return channel. The echo repeats the original header. Its data field carries the execution timestamp, or the requested read value when the command asks for data. A queued command that arrives while the queue is full is refused, and a distinct error echo is returned in its place.

The register bank and the chip-side shifter sit outside this block. It drives them only through single-cycle strobes with an address, a data word or a payload alongside.

Top module: `timed_cmd_engine`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `echoValid` and every strobe output are low, the queue is empty and no hold is armed. The timer restarts at 0.
- R2: A word is accepted only when `pktValid` is high, bits 31:30 are 2'b11 and bits 29:28 (the class) are not 2'b11. Any other word gives no echo, no strobe and no change to the queue or the hold.
- R3: An immediate command has class 2'b00. It executes at the clock edge that samples it, and its echo and strobe are high during the next cycle. Opcode bits 27:24 select the action: 0 is interface reset (`ifaceRstPulse`), 1 is front-end reset (`feRstPulse`), 2 is timer read, 3 is hold-until-time.
- R4: Interface commands (class 2'b01) and chip commands (class 2'b10) are queued. They execute one per edge, in arrival order, no earlier than the edge after the edge that queued them. At most one command executes at any edge.
- R5: At an edge that samples an immediate command or a refused word, the head of the queue does not execute. It executes at a later edge.
- R6: The timer counts up by one at every edge and wraps from 32767 to 0. An echo for a command that returns no data carries, in bits 15:0, the zero-extended timer value at the execution edge.
- R7: Hold-until-time loads bits 14:0 as a target and arms the hold. A later hold command replaces the target. While the hold is armed, the queue head runs only at an edge where the timer equals the target. That one execution clears the hold.
- R8: A chip command, with any opcode, drives `chipCmdValid` for one cycle with `chipCmdWord` equal to bits 12:0 of the command.
- R9: Interface opcode 0 is a register write (`regWrPulse`, `regAddr` = bits 23:16, `regWrData` = bits 15:0). Opcode 1 is a register read (`regRdPulse`, `regAddr`), and its echo carries `regRdData` as sampled at the execution edge. Opcode 2 raises `injectPulse`.
- R10: A queued-class word that arrives while 128 entries are stored is not stored, even if the head leaves at that same edge. Its echo is {2'b11, 2'b00, 4'hF, bits 23:0 of the refused word}.
- R11: Interface reset empties the queue and disarms the hold at its execution edge.
- R12: An immediate opcode from 4 to 15 and an interface opcode from 3 to 15 still produce an echo carrying the timestamp, but raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pktValid | input | 1 | Control word present this cycle |
| pktWord | input | 32 | Control word: header in 31:16, data in 15:0 |
| regRdData | input | 16 | Read value offered by the register bank |
| echoValid | output | 1 | Echo word valid this cycle |
| echoWord | output | 32 | Echo word |
| ifaceRstPulse | output | 1 | Interface reset strobe |
| feRstPulse | output | 1 | Front-end reset strobe |
| regWrPulse | output | 1 | Register write strobe |
| regRdPulse | output | 1 | Register read strobe |
| injectPulse | output | 1 | Chip pulse strobe |
| regAddr | output | 8 | Register address for a write or a read |
| regWrData | output | 16 | Register write value |
| chipCmdValid | output | 1 | Chip command strobe |
| chipCmdWord | output | 13 | Chip command payload |

## Verification
Every result of this block is a registered output. An immediate command or a refused word produces its echo and strobe one cycle after the edge that samples it. A queued command produces them one cycle after the edge where it leaves the queue, which is at least two edges after it arrives and later still under a hold or a stall.

The bench holds a behavioural model that advances once per rising edge from the same inputs. The model keeps a queue, a hold flag and an integer timer. The bench drives inputs and compares every output on the falling edge, half a cycle after the registers settle. Each comparison therefore lands exactly on the cycle the model predicts, and a shift of one cycle in either direction shows up as a mismatch.

// File: rtl/tce_pkg.sv
package tce_pkg;

  typedef enum logic [1:0] {
    CLS_IMM   = 2'b00,
    CLS_IFACE = 2'b01,
    CLS_CHIP  = 2'b10,
    CLS_RSV   = 2'b11
  } cmdClass_e;

  localparam logic [1:0] HDR_MARK   = 2'b11;

  // immediate opcodes
  localparam logic [3:0] OP_IFRST   = 4'd0;
  localparam logic [3:0] OP_FERST   = 4'd1;
  localparam logic [3:0] OP_TREAD   = 4'd2;
  localparam logic [3:0] OP_EXECAT  = 4'd3;
  // interface opcodes
  localparam logic [3:0] OP_REGWR   = 4'd0;
  localparam logic [3:0] OP_REGRD   = 4'd1;
  localparam logic [3:0] OP_PULSE   = 4'd2;
  // status opcode of a refusal echo
  localparam logic [3:0] OP_REJECT  = 4'hF;

  typedef enum logic [1:0] {
    ECHO_NONE,
    ECHO_IN,
    ECHO_HEAD,
    ECHO_ERR
  } echoSrc_e;

  typedef struct packed {
    logic     push;
    logic     pop;
    logic     flush;
    echoSrc_e echoSrc;
    logic     useRdData;
    logic     ifaceRst;
    logic     feRst;
    logic     regWr;
    logic     regRd;
    logic     pulse;
    logic     chipCmd;
  } ctrlStrobe_t;

  // Marks the side effects of executing command word w on top of base.
  function automatic ctrlStrobe_t markExec(input ctrlStrobe_t base, input logic [31:0] w);
    ctrlStrobe_t s;
    logic [3:0] op;
    s  = base;
    op = w[27:24];
    case (cmdClass_e'(w[29:28]))
      CLS_IMM: begin
        s.ifaceRst = (op == OP_IFRST);
        s.feRst    = (op == OP_FERST);
      end
      CLS_IFACE: begin
        s.regWr     = (op == OP_REGWR);
        s.regRd     = (op == OP_REGRD);
        s.useRdData = (op == OP_REGRD);
        s.pulse     = (op == OP_PULSE);
      end
      CLS_CHIP: s.chipCmd = 1'b1;
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl
  import tce_pkg::*;
#(
  parameter int TIMER_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pktValid,
  input  logic [31:0]        pktWord,
  input  logic [31:0]        headWord,
  input  logic               qEmpty,
  input  logic               qFull,
  input  logic [TIMER_W-1:0] timer,
  output ctrlStrobe_t        strb,
  output logic               holdArmed,
  output logic [TIMER_W-1:0] holdTarget
);

  cmdClass_e  inCls;
  logic [3:0] inOp;
  logic       inWell;
  logic       inImm;
  logic       inQueued;
  logic       inReject;
  logic       timeReached;
  logic       popNow;

  always_comb begin
    inCls       = cmdClass_e'(pktWord[29:28]);
    inOp        = pktWord[27:24];
    inWell      = pktValid && (pktWord[31:30] == HDR_MARK) && (inCls != CLS_RSV);
    inImm       = inWell && (inCls == CLS_IMM);
    inQueued    = inWell && ((inCls == CLS_IFACE) || (inCls == CLS_CHIP));
    inReject    = inQueued && qFull;
    timeReached = !holdArmed || (timer == holdTarget);
    popNow      = !qEmpty && !inImm && !inReject && timeReached;
  end

  always_comb begin
    strb       = '0;
    strb.push  = inQueued && !qFull;
    strb.pop   = popNow;
    strb.flush = inImm && (inOp == OP_IFRST);
    if (inImm) begin
      strb.echoSrc = ECHO_IN;
      strb         = markExec(strb, pktWord);
    end else if (inReject) begin
      strb.echoSrc = ECHO_ERR;
    end else if (popNow) begin
      strb.echoSrc = ECHO_HEAD;
      strb         = markExec(strb, headWord);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdArmed  <= 1'b0;
      holdTarget <= '0;
    end else if (strb.flush) begin
      holdArmed  <= 1'b0;
    end else if (inImm && (inOp == OP_EXECAT)) begin
      holdArmed  <= 1'b1;
      holdTarget <= pktWord[TIMER_W-1:0];
    end else if (popNow) begin
      holdArmed  <= 1'b0;
    end
  end

endmodule

// File: rtl/tce_datapath.sv
module tce_datapath
  import tce_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int TIMER_W = 15,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [31:0]        pktWord,
  input  logic [15:0]        regRdData,
  output logic [31:0]        headWord,
  output logic               qEmpty,
  output logic               qFull,
  output logic [CW-1:0]      qCount,
  output logic [TIMER_W-1:0] timer,
  output logic               echoValid,
  output logic [31:0]        echoWord,
  output logic               ifaceRstPulse,
  output logic               feRstPulse,
  output logic               regWrPulse,
  output logic               regRdPulse,
  output logic               injectPulse,
  output logic [7:0]         regAddr,
  output logic [15:0]        regWrData,
  output logic               chipCmdValid,
  output logic [12:0]        chipCmdWord
);

  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [31:0]   fifoMem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [31:0]   srcWord;
  logic [15:0]   tsData;
  logic [15:0]   execData;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) fifoMem[wrPtr] <= pktWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else if (strb.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
      qCount <= qCount + CW'(strb.push) - CW'(strb.pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else       timer <= timer + 1'b1;
  end

  always_comb begin
    headWord = fifoMem[rdPtr];
    qEmpty   = (qCount == '0);
    qFull    = (qCount == CW'(DEPTH));
    srcWord  = (strb.echoSrc == ECHO_HEAD) ? headWord : pktWord;
    tsData   = 16'(timer);
    execData = strb.useRdData ? regRdData : tsData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      echoValid     <= 1'b0;
      echoWord      <= '0;
      ifaceRstPulse <= 1'b0;
      feRstPulse    <= 1'b0;
      regWrPulse    <= 1'b0;
      regRdPulse    <= 1'b0;
      injectPulse   <= 1'b0;
      chipCmdValid  <= 1'b0;
      regAddr       <= '0;
      regWrData     <= '0;
      chipCmdWord   <= '0;
    end else begin
      echoValid <= (strb.echoSrc != ECHO_NONE);
      case (strb.echoSrc)
        ECHO_ERR:           echoWord <= {HDR_MARK, CLS_IMM, OP_REJECT, srcWord[23:0]};
        ECHO_IN, ECHO_HEAD: echoWord <= {srcWord[31:16], execData};
        default:            echoWord <= echoWord;
      endcase
      ifaceRstPulse <= strb.ifaceRst;
      feRstPulse    <= strb.feRst;
      regWrPulse    <= strb.regWr;
      regRdPulse    <= strb.regRd;
      injectPulse   <= strb.pulse;
      chipCmdValid  <= strb.chipCmd;
      if (strb.regWr || strb.regRd) regAddr <= srcWord[23:16];
      if (strb.regWr) regWrData <= srcWord[15:0];
      if (strb.chipCmd) chipCmdWord <= srcWord[12:0];
    end
  end

endmodule

// File: rtl/timed_cmd_engine.sv
module timed_cmd_engine
  import tce_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int TIMER_W = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic [31:0] pktWord,
  input  logic [15:0] regRdData,
  output logic        echoValid,
  output logic [31:0] echoWord,
  output logic        ifaceRstPulse,
  output logic        feRstPulse,
  output logic        regWrPulse,
  output logic        regRdPulse,
  output logic        injectPulse,
  output logic [7:0]  regAddr,
  output logic [15:0] regWrData,
  output logic        chipCmdValid,
  output logic [12:0] chipCmdWord
);

  localparam int CW = $clog2(DEPTH + 1);

  ctrlStrobe_t        strb;
  logic [31:0]        headWord;
  logic               qEmpty;
  logic               qFull;
  logic [CW-1:0]      qCount;
  logic [TIMER_W-1:0] timer;
  logic               holdArmed;
  logic [TIMER_W-1:0] holdTarget;

  tce_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pktValid  (pktValid),
    .pktWord   (pktWord),
    .headWord  (headWord),
    .qEmpty    (qEmpty),
    .qFull     (qFull),
    .timer     (timer),
    .strb      (strb),
    .holdArmed (holdArmed),
    .holdTarget(holdTarget)
  );

  tce_datapath #(.DEPTH(DEPTH), .TIMER_W(TIMER_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .pktWord      (pktWord),
    .regRdData    (regRdData),
    .headWord     (headWord),
    .qEmpty       (qEmpty),
    .qFull        (qFull),
    .qCount       (qCount),
    .timer        (timer),
    .echoValid    (echoValid),
    .echoWord     (echoWord),
    .ifaceRstPulse(ifaceRstPulse),
    .feRstPulse   (feRstPulse),
    .regWrPulse   (regWrPulse),
    .regRdPulse   (regRdPulse),
    .injectPulse  (injectPulse),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .chipCmdValid (chipCmdValid),
    .chipCmdWord  (chipCmdWord)
  );

endmodule

// File: rtl/tce_checker.sv
module tce_checker #(
  parameter int DEPTH   = 128,
  parameter int TIMER_W = 15,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               pktValid,
  input logic [31:0]        pktWord,
  input logic               echoValid,
  input logic [31:0]        echoWord,
  input logic               ifaceRstPulse,
  input logic               feRstPulse,
  input logic               regWrPulse,
  input logic               regRdPulse,
  input logic               injectPulse,
  input logic               chipCmdValid,
  input logic [CW-1:0]      qCount,
  input logic [TIMER_W-1:0] timer,
  input logic               holdArmed,
  input logic [TIMER_W-1:0] holdTarget
);

  logic [5:0] strobes;
  assign strobes = {ifaceRstPulse, feRstPulse, regWrPulse, regRdPulse, injectPulse, chipCmdValid};

  // R1: quiet and empty while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!echoValid && strobes == '0 && qCount == '0 && !holdArmed)
        else $error("reset state not quiet");
    end
  end

  p_bad_word_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktWord[31:30] != 2'b11 && qCount == '0) |=> !echoValid);

  p_strobe_has_echo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes != '0) |-> echoValid);

  p_one_exec_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  p_timer_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> timer == $past(timer) + 1'b1);

  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdArmed && timer != holdTarget && !pktValid) |=> !echoValid);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CW'(DEPTH));

  p_full_refuses_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktWord[31:30] == 2'b11 && (pktWord[29:28] == 2'b01 || pktWord[29:28] == 2'b10)
     && qCount == CW'(DEPTH)) |=> (echoValid && echoWord[27:24] == 4'hF));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktWord[31:24] == 8'hC0) |=> (qCount == '0 && !holdArmed));

endmodule

bind timed_cmd_engine tce_checker #(.DEPTH(DEPTH), .TIMER_W(TIMER_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pktValid     (pktValid),
  .pktWord      (pktWord),
  .echoValid    (echoValid),
  .echoWord     (echoWord),
  .ifaceRstPulse(ifaceRstPulse),
  .feRstPulse   (feRstPulse),
  .regWrPulse   (regWrPulse),
  .regRdPulse   (regRdPulse),
  .injectPulse  (injectPulse),
  .chipCmdValid (chipCmdValid),
  .qCount       (qCount),
  .timer        (timer),
  .holdArmed    (holdArmed),
  .holdTarget   (holdTarget)
);

// File: tb/timed_cmd_engine_test.sv
module timed_cmd_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [31:0] pktWord = '0;
  logic [15:0] regRdData = 16'h3C5A;
  logic        echoValid;
  logic [31:0] echoWord;
  logic        ifaceRstPulse, feRstPulse, regWrPulse, regRdPulse, injectPulse, chipCmdValid;
  logic [7:0]  regAddr;
  logic [15:0] regWrData;
  logic [12:0] chipCmdWord;

  timed_cmd_engine uut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktWord(pktWord), .regRdData(regRdData),
    .echoValid(echoValid), .echoWord(echoWord), .ifaceRstPulse(ifaceRstPulse),
    .feRstPulse(feRstPulse), .regWrPulse(regWrPulse), .regRdPulse(regRdPulse),
    .injectPulse(injectPulse), .regAddr(regAddr), .regWrData(regWrData),
    .chipCmdValid(chipCmdValid), .chipCmdWord(chipCmdWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] mq[$];
  bit          mHold = 1'b0;
  int          mTgt = 0;
  int          mTimer = 0;
  int          mTs;
  bit          mWell, mImm, mQd, mRej, mTimeOk, mPop, seenEdge = 1'b0;
  logic [31:0] mHead;

  bit          eEcho, eIf, eFe, eWr, eRd, ePul, eChip;
  logic [31:0] eWord;
  logic [7:0]  eAddr;
  logic [15:0] eWrData;
  logic [12:0] eChipWord;
  string       eReq = "R1";

  task automatic clearExp();
    eEcho = 0; eIf = 0; eFe = 0; eWr = 0; eRd = 0; ePul = 0; eChip = 0;
  endtask

  task automatic modelExec(input logic [31:0] w);
    logic [1:0]  cls;
    logic [3:0]  op;
    logic [15:0] d;
    cls = w[29:28];
    op  = w[27:24];
    d   = (cls == 2'b01 && op == 4'd1) ? regRdData : 16'(mTs);
    eEcho = 1;
    eWord = {w[31:16], d};
    if (cls == 2'b00) begin
      eIf  = (op == 4'd0);
      eFe  = (op == 4'd1);
      eReq = (op > 4'd3) ? "R12" : "R3";
    end else if (cls == 2'b01) begin
      eWr  = (op == 4'd0);
      eRd  = (op == 4'd1);
      ePul = (op == 4'd2);
      if (op <= 4'd1) eAddr = w[23:16];
      if (op == 4'd0) eWrData = w[15:0];
      eReq = (op > 4'd2) ? "R12" : "R9";
    end else begin
      eChip     = 1;
      eChipWord = w[12:0];
      eReq      = "R8";
    end
  endtask

  always @(posedge clk) begin
    seenEdge = 1'b1;
    clearExp();
    if (!rstN) begin
      mq.delete();
      mHold  = 0;
      mTimer = 0;
      eReq   = "R1";
    end else begin
      mTs     = mTimer;
      mWell   = pktValid && pktWord[31:30] == 2'b11 && pktWord[29:28] != 2'b11;
      mImm    = mWell && pktWord[29:28] == 2'b00;
      mQd     = mWell && !mImm;
      mRej    = mQd && mq.size() == DEPTH;
      mTimeOk = !mHold || (mTimer == mTgt);
      mPop    = mq.size() > 0 && !mImm && !mRej && mTimeOk;
      eReq    = (pktValid && !mWell) ? "R2" : "R5";
      if (mImm) begin
        modelExec(pktWord);
        if (pktWord[27:24] == 4'd0) begin
          mq.delete();
          mHold = 0;
          eReq  = "R11";
        end else if (pktWord[27:24] == 4'd3) begin
          mHold = 1;
          mTgt  = int'(pktWord[14:0]);
          eReq  = "R7";
        end
      end else if (mRej) begin
        eEcho = 1;
        eWord = {8'hCF, pktWord[23:0]};
        eReq  = "R10";
      end else if (mPop) begin
        mHead = mq.pop_front();
        modelExec(mHead);
        if (mHold) eReq = "R7";
        else if (eReq == "R12") eReq = "R12";
        else eReq = "R4";
        mHold = 0;
      end
      if (mQd && !mRej) mq.push_back(pktWord);
      mTimer = (mTimer + 1) % 32768;
    end
  end

  // ---------------- comparison, away from the active edge ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seenEdge && !done) begin
      check(echoValid == eEcho, eReq, "echoValid", 32'(echoValid), 32'(eEcho));
      // R6: the data field of a no-data echo is the execution timestamp
      if (eEcho) check(echoWord == eWord, (eReq == "R5") ? "R6" : eReq, "echoWord", echoWord, eWord);
      check(ifaceRstPulse == eIf, "R11", "ifaceRstPulse", 32'(ifaceRstPulse), 32'(eIf));
      check(feRstPulse == eFe, "R3", "feRstPulse", 32'(feRstPulse), 32'(eFe));
      check(regWrPulse == eWr, "R9", "regWrPulse", 32'(regWrPulse), 32'(eWr));
      check(regRdPulse == eRd, "R9", "regRdPulse", 32'(regRdPulse), 32'(eRd));
      check(injectPulse == ePul, "R9", "injectPulse", 32'(injectPulse), 32'(ePul));
      check(chipCmdValid == eChip, "R8", "chipCmdValid", 32'(chipCmdValid), 32'(eChip));
      if (eWr || eRd) check(regAddr == eAddr, "R9", "regAddr", 32'(regAddr), 32'(eAddr));
      if (eWr) check(regWrData == eWrData, "R9", "regWrData", 32'(regWrData), 32'(eWrData));
      if (eChip) check(chipCmdWord == eChipWord, "R8", "chipCmdWord", 32'(chipCmdWord), 32'(eChipWord));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [31:0] w);
    pktValid = 1'b1;
    pktWord  = w;
    @(negedge clk);
    pktValid = 1'b0;
    pktWord  = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] holdAt(input int ahead);
    return {16'hC300, 1'b0, 15'((mTimer + ahead) % 32768)};
  endfunction

  task automatic report();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    report();
  end

  initial begin
    idle(3);
    rstN = 1'b1;                       // R1: quiet first cycles
    idle(3);
    // R2: malformed words
    send(32'h4100_1111);
    send(32'hF000_2222);
    send(32'h3200_0000);
    idle(2);
    // R3 / R12: immediate commands
    send(32'hC100_0000);
    send(32'hC200_0000);
    send(32'hC700_0000);
    idle(2);
    // R4 / R8 / R9 / R12: back-to-back queued, then R5 stall by immediates
    regRdData = 16'h9E21;
    send(32'hD012_BEEF);
    send(32'hD134_0000);
    send(32'hD200_0000);
    send(32'hE5AA_1ABC);
    send(32'hD900_0000);
    send(32'hC100_0000);
    send(32'hC200_0000);
    idle(10);
    // R5: immediates arriving while the queue drains
    for (int i = 0; i < 5; i++) send(32'hD200_0000 | i);
    send(32'hC100_0000);
    send(32'hC100_0001);
    send(32'hC700_0002);
    idle(10);
    // R7: hold then three queued commands
    send(holdAt(20));
    send(32'hE000_0001);
    send(32'hE000_0002);
    send(32'hD200_0003);
    idle(40);
    // R7: a second hold replaces the first target
    send(holdAt(100));
    send(holdAt(15));
    send(32'hE000_0ACE);
    idle(30);
    // R10: fill beyond capacity under a far hold, then R11 flush
    send(holdAt(2000));
    for (int i = 0; i < DEPTH + 3; i++) send(32'hD500_0000 | i);
    idle(2);
    send(32'hC000_0000);
    idle(5);
    send(32'hE000_0555);
    idle(5);
    // R6: hold across a timer wrap
    send(32'hC300_0005);
    send(32'hE000_0777);
    while (mq.size() > 0) @(negedge clk);
    idle(5);
    report();
  end

endmodule